// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

This block watches the latest raw converter code of every sensing point in several sensor banks. Each code is compared against five programmable thresholds, and the result is kept as sticky interrupt status. The raw code falls as temperature rises. "Hot" and "above high offset" therefore mean a code numerically below the threshold, and "cold" and "below low offset" mean a code above it. A detection count makes an event wait for a run of consecutive qualifying samples.

All banks share one small register window. A bank-select register picks which bank's registers the window shows. Each bank merges its points into one protection value, using the mean, the hottest point or one chosen point. The interrupt line is the OR, over all banks, of status ANDed with enable. A per-bank summary output and a global status word report pending banks as active-low bits.

Top module: `thermon_monitor`

## Requirements
- R1: For point sp, status bit sp*5+0 (cold) is set by a sample whose code is greater than the cold threshold. Bit sp*5+1 (hot) needs a code less than the hot threshold. Bit sp*5+2 (below low offset) needs a code greater than the low-offset threshold. Bit sp*5+3 (above high offset) needs a code less than the high-offset threshold.
- R2: Once the hot event of a point has fired, a qualifying sample with a code greater than the hot-to-normal threshold sets bit sp*5+4. That event then re-arms only after another hot event. A point that has never fired hot never sets this bit.
- R3: With detection count D (register 8, low 4 bits), a condition fires on its (D+1)th consecutive qualifying sample and its run then restarts. A non-qualifying sample also restarts the run. D=0 fires on every qualifying sample.
- R4: Every accepted sample of point sp sets bit 16+sp. Bit 19+sp is set on every (D+1)th accepted sample of that point.
- R5: A pulse on a bank's timeout input sets status bit 15 of that bank.
- R6: A sample at a point whose bit in the point-mask register (register 0) is clear is ignored. It sets no status bit and does not replace that point's latest code.
- R7: Status bits stay set until the status register (register 2) of the selected bank is read. The read returns the current bits and clears them. A bit set in the same cycle as the read survives.
- R8: irq_o is high when any bank has a status bit whose matching bit in its interrupt-enable register (register 1) is set. Clearing the enable masks the line but leaves the status.
- R9: In the global status word (register 14) and on bank_pend_n_o, bit b is 0 while bank b has an enabled pending status bit, and 1 otherwise.
- R10: The bank select is the low 4 bits of register 15, and the upper written bits are dropped. With a select of NBANKS or more, bank-register reads return 0 and writes are dropped.
- R11: The protection result (register 10) depends on the mode field at bits 17:16 of register 9. Mode 0 gives the floor of the mean of the latest codes of the enabled points. Mode 1 gives the smallest such code, which is the hottest point. Mode 2 gives the latest code of the point named in bits 1:0. Mode 3, no enabled point in modes 0 and 1, or a point index of NPTS or more gives 0.
- R12: The register map is 0 point mask, 1 interrupt enable, 3 low offset, 4 high offset, 5 hot, 6 cold, 7 hot-to-normal and 8 detection count. Each of these is per bank and reads back what was written, truncated to its field width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status on register 2) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| smp_vld_i | input | NBANKS*NPTS | Per-point sample strobes, index bank*NPTS+point |
| smp_raw_i | input | NBANKS*NPTS*ADCW | Per-point raw codes, same indexing |
| tmo_i | input | NBANKS | Per-bank timeout pulses |
| irq_o | output | 1 | Masked interrupt line |
| bank_pend_n_o | output | NBANKS | Active-low per-bank pending summary |

## Verification
The bench goes after the cold/hot polarity: swapping the comparison direction would set the cold bit for hot codes. It drives runs that are broken by one non-qualifying sample, which exposes a counter that does not restart or fires one sample late. It also issues a status read in the same cycle as a new sample, where a naive clear would lose the new event. A hot-to-normal sample sent without a prior hot event must stay silent. Masked points are checked through the protection result, and bank selects beyond the last bank are tried. A random run on one bank compares every status read against a model built from the requirements.

// File: rtl/thermon_pkg.sv
package thermon_pkg;
    localparam int REG_W     = 32;
    localparam int EV_COLD   = 0;
    localparam int EV_HOT    = 1;
    localparam int EV_LOW    = 2;
    localparam int EV_HIGH   = 3;
    localparam int EV_H2N    = 4;
    localparam int EV_PER_PT = 5;
    localparam int TMO_BIT   = 15;
    localparam int IMM_BASE  = 16;
    localparam int FILT_BASE = 19;

    typedef enum logic [3:0] {
        A_PTMASK  = 4'd0,
        A_IEN     = 4'd1,
        A_STAT    = 4'd2,
        A_LOWOFS  = 4'd3,
        A_HIGHOFS = 4'd4,
        A_HOT     = 4'd5,
        A_COLD    = 4'd6,
        A_H2N     = 4'd7,
        A_DET     = 4'd8,
        A_PROT    = 4'd9,
        A_PRES    = 4'd10,
        A_GSTAT   = 4'd14,
        A_BSEL    = 4'd15
    } addr_e;

    typedef enum logic [1:0] {
        PM_AVG = 2'd0,
        PM_MAX = 2'd1,
        PM_SEL = 2'd2,
        PM_RSV = 2'd3
    } pmode_e;
endpackage

// File: rtl/thermon_point.sv
module thermon_point
    import thermon_pkg::*;
#(
    parameter int ADCW = 12,
    parameter int CNTW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic [ADCW-1:0]      raw_i,
    input  logic [ADCW-1:0]      thr_low_i,
    input  logic [ADCW-1:0]      thr_high_i,
    input  logic [ADCW-1:0]      thr_hot_i,
    input  logic [ADCW-1:0]      thr_cold_i,
    input  logic [ADCW-1:0]      thr_h2n_i,
    input  logic [CNTW-1:0]      det_i,
    output logic [EV_PER_PT-1:0] evt_o,
    output logic                 imm_o,
    output logic                 filt_o
);
    typedef struct packed {
        logic [EV_PER_PT-1:0][CNTW-1:0] run;
        logic [CNTW-1:0]                fcnt;
        logic                           hot;
    } pt_st_t;

    pt_st_t                 st_q, st_d;
    logic [EV_PER_PT-1:0]   cond;
    logic [EV_PER_PT-1:0]   fire;
    logic                   filt;

    always_comb begin
        cond          = '0;
        cond[EV_COLD] = raw_i > thr_cold_i;
        cond[EV_HOT]  = raw_i < thr_hot_i;
        cond[EV_LOW]  = raw_i > thr_low_i;
        cond[EV_HIGH] = raw_i < thr_high_i;
        cond[EV_H2N]  = st_q.hot && (raw_i > thr_h2n_i);
        st_d = st_q;
        fire = '0;
        filt = 1'b0;
        for (int n = 0; n < EV_PER_PT; n++) begin
            fire[n] = vld_i && cond[n] && (st_q.run[n] >= det_i);
            if (vld_i) begin
                st_d.run[n] = (cond[n] && !fire[n]) ? st_q.run[n] + 1'b1 : '0;
            end
        end
        if (vld_i) begin
            filt      = st_q.fcnt >= det_i;
            st_d.fcnt = filt ? '0 : st_q.fcnt + 1'b1;
        end
        if (fire[EV_HOT]) begin
            st_d.hot = 1'b1;
        end else if (fire[EV_H2N]) begin
            st_d.hot = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o  = fire;
    assign imm_o  = vld_i;
    assign filt_o = filt;

    // a zero detection count turns one hot sample straight into an event
    assert_single_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && det_i == '0 && raw_i < thr_hot_i) |-> evt_o[EV_HOT]);

    // returning to normal disarms the hot-to-normal condition
    assert_h2n_disarms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o[EV_H2N] && !evt_o[EV_HOT]) |=> !st_q.hot);
endmodule

// File: rtl/thermon_bank.sv
module thermon_bank
    import thermon_pkg::*;
#(
    parameter int NPTS = 3,
    parameter int ADCW = 12,
    parameter int CNTW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [3:0]           addr_i,
    input  logic [REG_W-1:0]     wdata_i,
    output logic [REG_W-1:0]     rdata_o,
    input  logic [NPTS-1:0]      vld_i,
    input  logic [NPTS*ADCW-1:0] raw_i,
    input  logic                 tmo_i,
    output logic                 pend_o
);
    localparam int SUMW = ADCW + $clog2(NPTS + 1);

    typedef struct packed {
        logic [NPTS-1:0]            ptmask;
        logic [REG_W-1:0]           ien;
        logic [REG_W-1:0]           stat;
        logic [ADCW-1:0]            thr_low;
        logic [ADCW-1:0]            thr_high;
        logic [ADCW-1:0]            thr_hot;
        logic [ADCW-1:0]            thr_cold;
        logic [ADCW-1:0]            thr_h2n;
        logic [CNTW-1:0]            det;
        logic [1:0]                 pmode;
        logic [1:0]                 psel;
        logic [NPTS-1:0][ADCW-1:0]  last;
    } bank_st_t;

    bank_st_t                         st_q, st_d;
    logic [NPTS-1:0]                  gvld;
    logic [NPTS-1:0][EV_PER_PT-1:0]   evt;
    logic [NPTS-1:0]                  imm;
    logic [NPTS-1:0]                  filt;
    logic [REG_W-1:0]                 set_vec;
    logic                             clr;
    logic [SUMW-1:0]                  sum;
    logic [SUMW-1:0]                  n_en;
    logic [ADCW-1:0]                  mn;
    logic [ADCW-1:0]                  pres;

    assign gvld = vld_i & st_q.ptmask;
    assign clr  = sel_i && rd_i && (addr_i == A_STAT);

    for (genvar p = 0; p < NPTS; p++) begin : g_pt
        thermon_point #(.ADCW(ADCW), .CNTW(CNTW)) u_pt (
            .clk        (clk),
            .rst_n      (rst_n),
            .vld_i      (gvld[p]),
            .raw_i      (raw_i[p*ADCW +: ADCW]),
            .thr_low_i  (st_q.thr_low),
            .thr_high_i (st_q.thr_high),
            .thr_hot_i  (st_q.thr_hot),
            .thr_cold_i (st_q.thr_cold),
            .thr_h2n_i  (st_q.thr_h2n),
            .det_i      (st_q.det),
            .evt_o      (evt[p]),
            .imm_o      (imm[p]),
            .filt_o     (filt[p])
        );
    end

    always_comb begin
        set_vec          = '0;
        set_vec[TMO_BIT] = tmo_i;
        for (int p = 0; p < NPTS; p++) begin
            set_vec[p*EV_PER_PT +: EV_PER_PT] = evt[p];
            set_vec[IMM_BASE + p]             = imm[p];
            set_vec[FILT_BASE + p]            = filt[p];
        end
    end

    // protection path over the latest codes of enabled points
    always_comb begin
        sum  = '0;
        n_en = '0;
        mn   = '1;
        for (int p = 0; p < NPTS; p++) begin
            if (st_q.ptmask[p]) begin
                sum  = sum + SUMW'(st_q.last[p]);
                n_en = n_en + 1'b1;
                if (st_q.last[p] < mn) mn = st_q.last[p];
            end
        end
        pres = '0;
        case (st_q.pmode)
            PM_AVG:  if (n_en != '0) pres = ADCW'(sum / n_en);
            PM_MAX:  if (n_en != '0) pres = mn;
            PM_SEL:  if (int'(st_q.psel) < NPTS) pres = st_q.last[st_q.psel];
            default: pres = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = (clr ? '0 : st_q.stat) | set_vec;
        for (int p = 0; p < NPTS; p++) begin
            if (gvld[p]) st_d.last[p] = raw_i[p*ADCW +: ADCW];
        end
        if (sel_i && wr_i) begin
            case (addr_i)
                A_PTMASK:  st_d.ptmask   = wdata_i[NPTS-1:0];
                A_IEN:     st_d.ien      = wdata_i;
                A_LOWOFS:  st_d.thr_low  = wdata_i[ADCW-1:0];
                A_HIGHOFS: st_d.thr_high = wdata_i[ADCW-1:0];
                A_HOT:     st_d.thr_hot  = wdata_i[ADCW-1:0];
                A_COLD:    st_d.thr_cold = wdata_i[ADCW-1:0];
                A_H2N:     st_d.thr_h2n  = wdata_i[ADCW-1:0];
                A_DET:     st_d.det      = wdata_i[CNTW-1:0];
                A_PROT: begin
                    st_d.pmode = wdata_i[17:16];
                    st_d.psel  = wdata_i[1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_PTMASK:  rdata_o[NPTS-1:0] = st_q.ptmask;
            A_IEN:     rdata_o           = st_q.ien;
            A_STAT:    rdata_o           = st_q.stat;
            A_LOWOFS:  rdata_o[ADCW-1:0] = st_q.thr_low;
            A_HIGHOFS: rdata_o[ADCW-1:0] = st_q.thr_high;
            A_HOT:     rdata_o[ADCW-1:0] = st_q.thr_hot;
            A_COLD:    rdata_o[ADCW-1:0] = st_q.thr_cold;
            A_H2N:     rdata_o[ADCW-1:0] = st_q.thr_h2n;
            A_DET:     rdata_o[CNTW-1:0] = st_q.det;
            A_PROT: begin
                rdata_o[17:16] = st_q.pmode;
                rdata_o[1:0]   = st_q.psel;
            end
            A_PRES:    rdata_o[ADCW-1:0] = pres;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = |(st_q.stat & st_q.ien);

    // without a status read, no bit already set may drop
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat)));

    // after a status read only bits raised in that same cycle remain
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((st_q.stat & ~$past(set_vec)) == '0));

    // with no accepted sample, timeout or read the status holds
    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && gvld == '0 && !tmo_i) |=> (st_q.stat == $past(st_q.stat)));
endmodule

// File: rtl/thermon_monitor.sv
module thermon_monitor
    import thermon_pkg::*;
#(
    parameter int NBANKS = 4,
    parameter int NPTS   = 3,
    parameter int ADCW   = 12,
    parameter int CNTW   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr_i,
    input  logic                        reg_rd_i,
    input  logic [3:0]                  reg_addr_i,
    input  logic [REG_W-1:0]            reg_wdata_i,
    output logic [REG_W-1:0]            reg_rdata_o,
    input  logic [NBANKS*NPTS-1:0]      smp_vld_i,
    input  logic [NBANKS*NPTS*ADCW-1:0] smp_raw_i,
    input  logic [NBANKS-1:0]           tmo_i,
    output logic                        irq_o,
    output logic [NBANKS-1:0]           bank_pend_n_o
);
    localparam int BSELW = 4;

    typedef struct packed {
        logic [BSELW-1:0] bsel;
    } top_st_t;

    top_st_t                       st_q, st_d;
    logic [NBANKS-1:0]             pend;
    logic [NBANKS-1:0][REG_W-1:0]  bank_rd;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        thermon_bank #(.NPTS(NPTS), .ADCW(ADCW), .CNTW(CNTW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (st_q.bsel == BSELW'(b)),
            .wr_i    (reg_wr_i),
            .rd_i    (reg_rd_i),
            .addr_i  (reg_addr_i),
            .wdata_i (reg_wdata_i),
            .rdata_o (bank_rd[b]),
            .vld_i   (smp_vld_i[b*NPTS +: NPTS]),
            .raw_i   (smp_raw_i[b*NPTS*ADCW +: NPTS*ADCW]),
            .tmo_i   (tmo_i[b]),
            .pend_o  (pend[b])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr_i && reg_addr_i == A_BSEL) st_d.bsel = reg_wdata_i[BSELW-1:0];
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_BSEL:  reg_rdata_o[BSELW-1:0]  = st_q.bsel;
            A_GSTAT: reg_rdata_o[NBANKS-1:0] = ~pend;
            default: begin
                for (int b = 0; b < NBANKS; b++) begin
                    if (st_q.bsel == BSELW'(b)) reg_rdata_o = bank_rd[b];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o         = |pend;
    assign bank_pend_n_o = ~pend;

    // the line only drops after a register access (clearing read or enable write)
    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(reg_rd_i || reg_wr_i));

    // a bank leaves the pending state only after a register access
    assert_pend_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(bank_pend_n_o) > $countones($past(bank_pend_n_o)))
            |-> $past(reg_rd_i || reg_wr_i));
endmodule

// File: tb/test_thermon_monitor.sv
module test_thermon_monitor;
    localparam int NB = 4;
    localparam int NP = 3;
    localparam int AW = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 reg_wr = 1'b0;
    logic                 reg_rd = 1'b0;
    logic [3:0]           reg_addr = '0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic [NB*NP-1:0]     smp_vld = '0;
    logic [NB*NP*AW-1:0]  smp_raw = '0;
    logic [NB-1:0]        tmo = '0;
    logic                 irq;
    logic [NB-1:0]        pend_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    thermon_monitor #(.NBANKS(NB), .NPTS(NP), .ADCW(AW), .CNTW(4)) i_thermon_monitor (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .smp_vld_i(smp_vld), .smp_raw_i(smp_raw), .tmo_i(tmo),
        .irq_o(irq), .bank_pend_n_o(pend_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic smp(input int b, input int p, input int raw);
        @(negedge clk);
        smp_vld[b*NP+p] = 1'b1;
        smp_raw[(b*NP+p)*AW +: AW] = AW'(raw);
        @(negedge clk);
        smp_vld = '0;
    endtask

    task automatic tmo_pulse(input int b);
        @(negedge clk);
        tmo[b] = 1'b1;
        @(negedge clk);
        tmo = '0;
    endtask

    // bench model of one bank for the random phase
    int m_run [NP][5];
    int m_fc  [NP];
    bit m_hot [NP];
    logic [31:0] m_exp;
    int m_det;
    int t_cold, t_low, t_high, t_hot, t_h2n;

    function automatic void model_sample(input int p, input int raw);
        bit c [5];
        bit f [5];
        c[0] = raw > t_cold;
        c[1] = raw < t_hot;
        c[2] = raw > t_low;
        c[3] = raw < t_high;
        c[4] = m_hot[p] && (raw > t_h2n);
        for (int n = 0; n < 5; n++) begin
            f[n] = c[n] && (m_run[p][n] >= m_det);
            if (f[n]) m_exp[p*5+n] = 1'b1;
            m_run[p][n] = (c[n] && !f[n]) ? m_run[p][n] + 1 : 0;
        end
        m_exp[16+p] = 1'b1;
        if (m_fc[p] >= m_det) begin
            m_exp[19+p] = 1'b1;
            m_fc[p] = 0;
        end else begin
            m_fc[p]++;
        end
        if (f[1]) m_hot[p] = 1'b1;
        else if (f[4]) m_hot[p] = 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R8 irq after reset", {31'b0, irq}, 32'h0);
        chk("R9 pend_n after reset", {28'b0, pend_n}, 32'hF);
        rd(4'd14, d); chk("R9 global status after reset", d, 32'h0000000F);
        rd(4'd15, d); chk("R10 bank select after reset", d, 32'h0);

        // bank 0 setup, R12 readback
        wr(4'd6, 3000); wr(4'd3, 2500); wr(4'd4, 1500); wr(4'd5, 1000); wr(4'd7, 2000);
        wr(4'd0, 7); wr(4'd8, 0); wr(4'd1, 0);
        rd(4'd6, d); chk("R12 cold threshold readback", d, 32'd3000);
        rd(4'd7, d); chk("R12 h2n threshold readback", d, 32'd2000);
        wr(4'd3, 32'hFFFF_F9C4); rd(4'd3, d); chk("R12 low threshold truncation", d, 32'h9C4);
        wr(4'd3, 2500);

        // R1 cold side
        smp(0, 0, 3100);
        rd(4'd2, d); chk("R1 cold and low offset bits", d, 32'h0009_0005);
        rd(4'd2, d); chk("R7 status cleared by read", d, 32'h0);
        // R1 hot side
        smp(0, 1, 900);
        rd(4'd2, d); chk("R1 hot and high offset bits", d, 32'h0012_0140);
        // R2 hot-to-normal
        smp(0, 1, 2100);
        rd(4'd2, d); chk("R2 hot-to-normal after hot", d, 32'h0012_0200);
        smp(0, 2, 2100);
        rd(4'd2, d); chk("R2 no hot-to-normal without hot", d, 32'h0024_0000);

        // R3/R4 detection count 2
        wr(4'd8, 2);
        smp(0, 0, 3100); smp(0, 0, 3100);
        rd(4'd2, d); chk("R3 two samples below count", d, 32'h0001_0000);
        smp(0, 0, 2000);
        rd(4'd2, d); chk("R4 filtered on third sample", d, 32'h0009_0000);
        smp(0, 0, 3100); smp(0, 0, 3100);
        rd(4'd2, d); chk("R3 run restarted by miss", d, 32'h0001_0000);
        smp(0, 0, 3100);
        rd(4'd2, d); chk("R3 fires on third qualifying", d, 32'h0009_0005);
        wr(4'd8, 0);

        // R6 masked point
        wr(4'd0, 5);
        smp(0, 1, 900);
        rd(4'd2, d); chk("R6 masked sample ignored", d, 32'h0);
        wr(4'd9, 32'h0002_0001);
        rd(4'd10, d); chk("R6 masked point keeps last code", d, 32'd2100);

        // R5 timeout
        tmo_pulse(0);
        rd(4'd2, d); chk("R5 timeout bit", d, 32'h0000_8000);

        // R7 read and new sample in the same cycle
        @(negedge clk);
        reg_addr = 4'd2; reg_rd = 1'b1;
        smp_vld[0] = 1'b1; smp_raw[0 +: AW] = AW'(2100);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; smp_vld = '0;
        chk("R7 read value before same-cycle set", d, 32'h0);
        rd(4'd2, d); chk("R7 same-cycle set survives", d, 32'h0009_0000);

        // R8/R9 interrupt line and summary
        wr(4'd1, 32'h0000_8000);
        tmo_pulse(0);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);
        chk("R9 pend_n bank0 low", {28'b0, pend_n}, 32'hE);
        rd(4'd14, d); chk("R9 global status active-low", d, 32'h0000000E);
        rd(4'd2, d);
        chk("R8 irq dropped by clear", {31'b0, irq}, 32'h0);
        chk("R9 pend_n released", {28'b0, pend_n}, 32'hF);
        wr(4'd1, 0);
        tmo_pulse(0);
        chk("R8 masked status no irq", {31'b0, irq}, 32'h0);
        rd(4'd2, d); chk("R8 masked status kept", d, 32'h0000_8000);

        // R10 bank select
        wr(4'd8, 5);
        wr(4'd15, 1); rd(4'd8, d); chk("R10 bank1 independent", d, 32'h0);
        wr(4'd8, 3);
        wr(4'd15, 0); rd(4'd8, d); chk("R10 bank0 untouched", d, 32'd5);
        wr(4'd15, 9); wr(4'd8, 7); rd(4'd8, d); chk("R10 out-of-range read zero", d, 32'h0);
        rd(4'd15, d); chk("R10 select readback", d, 32'd9);
        wr(4'd15, 32'h0000_00F1); rd(4'd15, d); chk("R10 low four bits only", d, 32'd1);
        rd(4'd8, d); chk("R10 out-of-range write dropped", d, 32'd3);
        wr(4'd15, 0); wr(4'd8, 0);

        // R11 protection modes
        wr(4'd0, 7);
        smp(0, 0, 1200); smp(0, 1, 1500); smp(0, 2, 1801);
        wr(4'd9, 32'h0000_0000); rd(4'd10, d); chk("R11 average", d, 32'd1500);
        wr(4'd9, 32'h0001_0000); rd(4'd10, d); chk("R11 hottest point", d, 32'd1200);
        wr(4'd9, 32'h0002_0002); rd(4'd10, d); chk("R11 selected point", d, 32'd1801);
        wr(4'd9, 32'h0002_0003); rd(4'd10, d); chk("R11 selected out of range", d, 32'h0);
        wr(4'd9, 32'h0003_0000); rd(4'd10, d); chk("R11 reserved mode", d, 32'h0);
        wr(4'd0, 5);
        wr(4'd9, 32'h0000_0000); rd(4'd10, d); chk("R11 average of two", d, 32'd1500);
        wr(4'd0, 0); rd(4'd10, d); chk("R11 no enabled point", d, 32'h0);
        rd(4'd2, d);

        // random phase on bank 2
        wr(4'd15, 2);
        t_cold = int'($urandom_range(4095)); t_low  = int'($urandom_range(4095));
        t_high = int'($urandom_range(4095)); t_hot  = int'($urandom_range(4095));
        t_h2n  = int'($urandom_range(4095)); m_det  = int'($urandom_range(2));
        wr(4'd6, t_cold); wr(4'd3, t_low); wr(4'd4, t_high);
        wr(4'd5, t_hot); wr(4'd7, t_h2n); wr(4'd8, m_det); wr(4'd0, 7);
        for (int p = 0; p < NP; p++) begin
            m_fc[p] = 0; m_hot[p] = 1'b0;
            for (int n = 0; n < 5; n++) m_run[p][n] = 0;
        end
        m_exp = '0;
        for (int i = 0; i < 240; i++) begin
            int p;
            int raw;
            p = int'($urandom_range(NP-1));
            raw = (i % 4 == 0) ? t_hot + int'($urandom_range(2)) - 1
                               : int'($urandom_range(4095));
            if (raw < 0) raw = 0;
            if (raw > 4095) raw = 4095;
            smp(2, p, raw);
            model_sample(p, raw);
            if (i % 8 == 7) begin
                rd(4'd2, d);
                chk("R1 R2 R3 R4 random status", d, m_exp);
                m_exp = '0;
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule